// File: doc/BRIEF.md
# Three-Wire Serial Tuning Register

This block receives tuning words over a write-only three-wire serial link made of an enable line, a data line and a shift clock. It fills a set of shadow latches that drive a frequency synthesizer. The latches are a four-bit band-switch field, a ten-bit main-count divider value, a five-bit swallow-count divider value and a control byte. The control byte holds the charge-pump current select, three test-mode bits, two reference-ratio select bits and a tuning-amplifier disable. The serial pins are asynchronous to the chip. They are sampled by a fast system clock through a two-stage synchronizer, and the edges of the serial clock and of the enable are detected in the system domain.

A frame is sent most-significant bit first while enable is high. A frame is either 19 bits long (band plus divider) or 27 bits long (band plus divider plus control byte). The fields commit at different points in the frame. The band field takes effect once four bits have arrived. The divider fields commit at the 19th bit. The control byte commits only at the 27th bit. If enable drops early, a field whose last bit has not arrived is never committed. A host can therefore retune the band switches alone with a short frame.

Top module: `tune_serial_rx`

## Requirements
- R1: After reset the outputs are: bandSel = 0 (all bands off), mainCount = 0, swallowCount = 0, cpHigh = 1 (250 uA current), testSel = 3'b000, refSel = 2'b00 (ratio 640), tuneOff = 1 (tuning amplifier off).
- R2: A bit is taken from serData only on a falling edge of serClk while serEn is high. Falling edges while serEn is low change no output.
- R3: Frame bits arrive MSB first. The first four bits are band bits 3 down to 0, and bandSel takes them on the 4th falling edge of the frame, before any other field commits.
- R4: Bits 5 to 14 of the frame are mainCount[9:0], MSB first, and bits 15 to 19 are swallowCount[4:0], MSB first. Both commit together on the 19th falling edge, and the control outputs are unchanged at that point.
- R5: Bits 20 to 27 of the frame are, in order: a don't-care bit, cpHigh (1 = 250 uA, 0 = 50 uA), testSel[2], testSel[1], testSel[0], refSel[1], refSel[0], tuneOff (1 = tuning output off). All of them commit together on the 27th falling edge. refSel 2'b01 selects ratio 512, 2'b11 selects 1024, and 2'b00 or 2'b10 selects 640.
- R6: If serEn falls after at least 4 but before 19 falling edges, only bandSel is updated. mainCount, swallowCount and the control outputs keep their previous values.
- R7: If serEn falls after at least 19 but before 27 falling edges, bandSel, mainCount and swallowCount are updated and the control outputs keep their previous values.
- R8: Falling edges after the 27th of a frame are ignored until serEn falls.
- R9: Each rising edge of serEn restarts the bit count, so a full frame that follows a truncated frame is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Active-low reset, standing in for power-on reset |
| serEn | input | 1 | Serial enable; a frame is sent while it is high |
| serData | input | 1 | Serial data, taken on falling serClk |
| serClk | input | 1 | Serial shift clock |
| bandSel | output | 4 | Band-switch outputs, 1 = band on |
| mainCount | output | 10 | Main-count divider value |
| swallowCount | output | 5 | Swallow-count divider value |
| cpHigh | output | 1 | Charge-pump current select, 1 = 250 uA |
| testSel | output | 3 | Test-mode select bits |
| refSel | output | 2 | Reference-ratio select |
| tuneOff | output | 1 | Tuning amplifier disable |

## Verification
A serial pin change needs two sysClk edges to pass the synchronizer. At the second edge the falling-edge detect is true. The bit counter and the shift register update at the third edge, together with the registered load strobe. The committed output appears after the fourth edge. The bench holds every serial clock phase, and every enable transition, for six sysClk cycles and samples one time unit after a rising edge. Every check after a falling edge therefore lands after the output has settled and before the next serial event. The mid-frame checks are placed right after the 4th and 19th falling edges, so they can see that one field has moved while a later field has not.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int BAND_W  = 4;
  localparam int MAIN_W  = 10;
  localparam int SWAL_W  = 5;
  localparam int CTL_W   = 8;
  localparam int DIV_W   = MAIN_W + SWAL_W;
  localparam int FRAME_W = BAND_W + DIV_W + CTL_W;
  localparam int SHIFT_W = (DIV_W > CTL_W) ? ((DIV_W > BAND_W) ? DIV_W : BAND_W)
                                           : ((CTL_W > BAND_W) ? CTL_W : BAND_W);
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic shiftEn;
    logic bandLd;
    logic divLd;
    logic ctlLd;
  } strobe_t;
endpackage

// File: rtl/tsr_sync.sv
module tsr_sync #(
  parameter int PINS   = 3,
  parameter int STAGES = 2
) (
  input  logic            sysClk,
  input  logic            rstN,
  input  logic [PINS-1:0] pinIn,
  output logic [PINS-1:0] pinLvl,
  output logic [PINS-1:0] pinPrev
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge sysClk or negedge rstN) begin
      if (!rstN) begin
        chain      <= '0;
        pinPrev[p] <= 1'b0;
      end else begin
        chain      <= {chain[STAGES-2:0], pinIn[p]};
        pinPrev[p] <= chain[STAGES-1];
      end
    end
    assign pinLvl[p] = chain[STAGES-1];
  end
endmodule

// File: rtl/tsr_ctrl.sv
module tsr_ctrl
  import tsr_pkg::*;
(
  input  logic    sysClk,
  input  logic    rstN,
  input  logic    enLvl,
  input  logic    enRise,
  input  logic    clkFall,
  output strobe_t strobes
);
  localparam logic [CNT_W-1:0] BAND_END  = CNT_W'(BAND_W);
  localparam logic [CNT_W-1:0] DIV_END   = CNT_W'(BAND_W + DIV_W);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_W);

  logic [CNT_W-1:0] bitCount;
  logic bandLdQ, divLdQ, ctlLdQ;
  logic shiftEn;

  assign shiftEn = clkFall && enLvl && !enRise && (bitCount < FRAME_END);

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      bandLdQ  <= 1'b0;
      divLdQ   <= 1'b0;
      ctlLdQ   <= 1'b0;
    end else begin
      bandLdQ <= 1'b0;
      divLdQ  <= 1'b0;
      ctlLdQ  <= 1'b0;
      if (enRise) begin
        bitCount <= '0;
      end else if (shiftEn) begin
        bitCount <= bitCount + 1'b1;
        bandLdQ  <= (bitCount == BAND_END - 1'b1);
        divLdQ   <= (bitCount == DIV_END - 1'b1);
        ctlLdQ   <= (bitCount == FRAME_END - 1'b1);
      end
    end
  end

  always_comb begin
    strobes.shiftEn = shiftEn;
    strobes.bandLd  = bandLdQ;
    strobes.divLd   = divLdQ;
    strobes.ctlLd   = ctlLdQ;
  end

  // R8
  count_cap_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    bitCount <= FRAME_END);

  // R2
  shift_gate_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    ((bitCount != $past(bitCount)) && (bitCount != '0)) |-> $past(enLvl && clkFall));

  // R9
  restart_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    enRise |=> (bitCount == '0));

  // R3
  load_onehot_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    $onehot0({bandLdQ, divLdQ, ctlLdQ}));
endmodule

// File: rtl/tsr_datapath.sv
module tsr_datapath
  import tsr_pkg::*;
(
  input  logic              sysClk,
  input  logic              rstN,
  input  logic              dataBit,
  input  strobe_t           strobes,
  output logic [BAND_W-1:0] bandSel,
  output logic [MAIN_W-1:0] mainCount,
  output logic [SWAL_W-1:0] swallowCount,
  output logic              cpHigh,
  output logic [2:0]        testSel,
  output logic [1:0]        refSel,
  output logic              tuneOff
);
  logic [SHIFT_W-1:0] shreg;
  logic unusedDontCare;

  assign unusedDontCare = shreg[CTL_W-1];

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      shreg <= '0;
    end else if (strobes.shiftEn) begin
      shreg <= {shreg[SHIFT_W-2:0], dataBit};
    end
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      bandSel <= '0;
    end else if (strobes.bandLd) begin
      bandSel <= shreg[BAND_W-1:0];
    end
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      mainCount    <= '0;
      swallowCount <= '0;
    end else if (strobes.divLd) begin
      mainCount    <= shreg[DIV_W-1:SWAL_W];
      swallowCount <= shreg[SWAL_W-1:0];
    end
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      cpHigh  <= 1'b1;
      testSel <= 3'b000;
      refSel  <= 2'b00;
      tuneOff <= 1'b1;
    end else if (strobes.ctlLd) begin
      cpHigh  <= shreg[6];
      testSel <= shreg[5:3];
      refSel  <= shreg[2:1];
      tuneOff <= shreg[0];
    end
  end

  // R6
  band_hold_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    !$past(strobes.bandLd) |-> $stable(bandSel));

  // R7
  div_hold_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    !$past(strobes.divLd) |-> ($stable(mainCount) && $stable(swallowCount)));

  // R5
  ctl_hold_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    !$past(strobes.ctlLd) |-> ($stable(cpHigh) && $stable(testSel) &&
                               $stable(refSel) && $stable(tuneOff)));
endmodule

// File: rtl/tune_serial_rx.sv
module tune_serial_rx
  import tsr_pkg::*;
(
  input  logic              sysClk,
  input  logic              rstN,
  input  logic              serEn,
  input  logic              serData,
  input  logic              serClk,
  output logic [BAND_W-1:0] bandSel,
  output logic [MAIN_W-1:0] mainCount,
  output logic [SWAL_W-1:0] swallowCount,
  output logic              cpHigh,
  output logic [2:0]        testSel,
  output logic [1:0]        refSel,
  output logic              tuneOff
);
  localparam int PIN_EN  = 2;
  localparam int PIN_DAT = 1;
  localparam int PIN_CLK = 0;

  logic [2:0] pinLvl, pinPrev;
  logic       enRise, clkFall;
  strobe_t    strobes;

  tsr_sync #(.PINS(3), .STAGES(2)) u_sync (
    .sysClk (sysClk),
    .rstN   (rstN),
    .pinIn  ({serEn, serData, serClk}),
    .pinLvl (pinLvl),
    .pinPrev(pinPrev)
  );

  assign enRise  = pinLvl[PIN_EN] && !pinPrev[PIN_EN];
  assign clkFall = !pinLvl[PIN_CLK] && pinPrev[PIN_CLK];

  tsr_ctrl u_ctrl (
    .sysClk (sysClk),
    .rstN   (rstN),
    .enLvl  (pinLvl[PIN_EN]),
    .enRise (enRise),
    .clkFall(clkFall),
    .strobes(strobes)
  );

  tsr_datapath u_dp (
    .sysClk      (sysClk),
    .rstN        (rstN),
    .dataBit     (pinLvl[PIN_DAT]),
    .strobes     (strobes),
    .bandSel     (bandSel),
    .mainCount   (mainCount),
    .swallowCount(swallowCount),
    .cpHigh      (cpHigh),
    .testSel     (testSel),
    .refSel      (refSel),
    .tuneOff     (tuneOff)
  );
endmodule

// File: tb/tune_serial_rx_tb.sv
module tune_serial_rx_tb;
  localparam int HOLD = 6;

  logic sysClk = 1'b0;
  logic rstN = 1'b0;
  logic serEn = 1'b0, serData = 1'b0, serClk = 1'b0;
  logic [3:0] bandSel;
  logic [9:0] mainCount;
  logic [4:0] swallowCount;
  logic cpHigh, tuneOff;
  logic [2:0] testSel;
  logic [1:0] refSel;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [3:0] expBand = 4'h0;
  logic [9:0] expMain = 10'h0;
  logic [4:0] expSwal = 5'h0;
  logic [7:0] expCtl  = 8'b0100_0001;

  always #4 sysClk = ~sysClk;

  tune_serial_rx u_dut (
    .sysClk(sysClk), .rstN(rstN), .serEn(serEn), .serData(serData), .serClk(serClk),
    .bandSel(bandSel), .mainCount(mainCount), .swallowCount(swallowCount),
    .cpHigh(cpHigh), .testSel(testSel), .refSel(refSel), .tuneOff(tuneOff)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(posedge sysClk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk({tag, " band"}, bandSel, expBand);
    chk({tag, " main"}, mainCount, expMain);
    chk({tag, " swallow"}, swallowCount, expSwal);
    chk({tag, " ctl"}, {cpHigh, testSel, refSel, tuneOff}, expCtl[6:0]);
  endtask

  function automatic logic [26:0] mk(input logic [3:0] b, input logic [9:0] m,
                                     input logic [4:0] s, input logic [7:0] c);
    return {b, m, s, c};
  endfunction

  task automatic serBit(input logic b);
    serData = b;
    serClk = 1'b1;
    waitCyc(HOLD);
    serClk = 1'b0;
    waitCyc(HOLD);
  endtask

  task automatic sendFrame(input logic [26:0] f, input int nBits, input int extra);
    serEn = 1'b1;
    waitCyc(HOLD);
    for (int i = 0; i < nBits; i++) serBit(f[26-i]);
    for (int i = 0; i < extra; i++) serBit(1'b1);
    serEn = 1'b0;
    waitCyc(HOLD);
    if (nBits >= 4) expBand = f[26:23];
    if (nBits >= 19) begin expMain = f[22:13]; expSwal = f[12:8]; end
    if (nBits >= 27) expCtl = f[7:0];
  endtask

  task automatic testReset();
    checkAll("R1 reset");
  endtask

  task automatic testEnableLow();
    for (int i = 0; i < 27; i++) serBit(1'b1);
    checkAll("R2 enable low");
  endtask

  task automatic testStaged();
    logic [26:0] f = mk(4'b1010, 10'h2A5, 5'h13, 8'b0010_1010);
    serEn = 1'b1;
    waitCyc(HOLD);
    for (int i = 0; i < 4; i++) serBit(f[26-i]);
    chk("R3 band at 4th", bandSel, 4'b1010);
    chk("R3 main held", mainCount, expMain);
    for (int i = 4; i < 19; i++) serBit(f[26-i]);
    chk("R4 main at 19th", mainCount, 10'h2A5);
    chk("R4 swallow at 19th", swallowCount, 5'h13);
    chk("R4 ctl held", {cpHigh, testSel, refSel, tuneOff}, expCtl[6:0]);
    for (int i = 19; i < 27; i++) serBit(f[26-i]);
    chk("R5 cp 50uA", cpHigh, 0);
    chk("R5 test", testSel, 3'b101);
    chk("R5 ref 512", refSel, 2'b01);
    chk("R5 tune on", tuneOff, 0);
    serEn = 1'b0;
    waitCyc(HOLD);
    expBand = 4'b1010; expMain = 10'h2A5; expSwal = 5'h13; expCtl = 8'b0010_1010;
    checkAll("R5 after frame");
  endtask

  task automatic testShortBand();
    sendFrame(mk(4'b0110, 10'h3FF, 5'h1F, 8'hFF), 10, 0);
    checkAll("R6 short frame");
  endtask

  task automatic testRestart();
    sendFrame(mk(4'b0001, 10'h3FF, 5'h1F, 8'b1100_0111), 27, 0);
    checkAll("R9 full after truncated");
  endtask

  task automatic testDivOnly();
    sendFrame(mk(4'b1000, 10'h020, 5'h00, 8'h00), 22, 0);
    checkAll("R7 22-bit frame");
  endtask

  task automatic testOverrun();
    sendFrame(mk(4'b0100, 10'h155, 5'h0A, 8'b0101_0110), 27, 6);
    checkAll("R8 extra clocks");
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(3);
    testReset();
    testEnableLow();
    testStaged();
    testShortBand();
    testRestart();
    testDivOnly();
    testOverrun();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge sysClk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule